// File: doc/BRIEF.md
# NAND Bus Timing Sequencer

This block turns single register writes and reads from a host into complete bus cycles on an 8-bit asynchronous NAND flash interface. A write to the command register produces one write cycle with the command-latch line high. A write to the address register produces one with the address-latch line high. A write to the data register produces a plain data write, and a read of the data register produces a plain data read. Only the low byte of any 32-bit value reaches the bus.

Each cycle runs through four phases: setup, strobe, hold and ready-wait. Each phase lasts for a count taken from a packed 32-bit timing register, and read and write cycles have their own sets of four counts. Chip enable is normally asserted only while a cycle runs, but a configuration bit can hold it low between cycles. The block reports the synchronised ready/busy line. It keeps two interrupt flags: one for a busy-to-ready transition and one for a terminal count on a data-cycle counter. Each flag can be masked and is cleared by writing a one. A control bit resets the whole controller.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), both latch lines are low, the data bus is not driven, `irq` and `seq_busy` are low, and every register reads zero.
- R2: Register word addresses: 0 configuration, 1 control, 2 status, 3 interrupt flags, 4 interrupt mask, 5 interrupt clear, 6 timing, 7 command, 8 address, 9 data, 10 cycle count. A write to address 7 issues one write cycle whose byte is `reg_wdata[7:0]`, with the command latch high and the address latch low throughout the strobe.
- R3: A write to address 8 issues one write cycle carrying `reg_wdata[7:0]` with the address latch high and the command latch low.
- R4: A write to address 9 issues one write cycle carrying `reg_wdata[7:0]` with both latch lines low.
- R5: Asserting `reg_rd` at address 9 issues one read cycle with the bus undriven. The byte on `nand_dq_in` in the last strobe clock appears on `rd_byte`, and `rd_done` pulses when the cycle ends.
- R6: The timing register holds eight 4-bit fields: read setup [3:0], read hold [7:4], read strobe [11:8], read ready-wait [15:12], and the write counterparts at [19:16], [23:20], [27:24] and [31:28]. A field value n gives a phase of n+1 clocks. Read cycles use the read fields, the other cycles use the write fields, and `seq_busy` stays high for the sum of the four phases.
- R7: Bit 5 of the configuration register holds chip enable low while the sequencer is idle. With bit 5 clear, chip enable is low exactly while `seq_busy` is high.
- R8: Cycle-issuing accesses (writes to 7, 8 or 9, or reads of 9) made while `seq_busy` is high are ignored and produce no strobe.
- R9: Status bit 0 follows `nand_rdy` after a two-flop synchroniser.
- R10: Interrupt flag bit 0 is set on a low-to-high transition of the synchronised ready line. Writing ones to address 5 clears the matching flags. `irq` is high when any flag is set and its mask bit (address 4) is set.
- R11: Address 10 holds a cycle count that each completed data cycle (read or write) lowers by one while it is nonzero. Interrupt flag bit 1 is set when a data cycle takes it from 1 to 0.
- R12: Writing bit 2 of the control register resets every register and returns the sequencer to idle at once, including when a cycle is part way through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed only for the data register) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| seq_busy | output | 1 | A bus cycle is in progress |
| rd_done | output | 1 | One-clock pulse at the end of a read cycle |
| rd_byte | output | 8 | Byte captured by the most recent read cycle |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven onto the bus |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Byte read from the bus |
| nand_rdy | input | 1 | Device ready/busy line, high when ready |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench uses the default parameters: 4-bit phase fields, a 16-bit cycle count and a two-stage ready synchroniser. With 4-bit fields, a timing word with different values in every read and write field lets one run separate the read and write phase selections by their busy lengths (10 and 11 clocks) and by their strobe widths. A setup field at its maximum of 15 keeps a cycle in its first phase long enough to test both a rejected second access and an abort by software reset. A count of 2 reaches the terminal count with one write and one read.

// File: rtl/nand_seq_pkg.sv
// nand_seq_pkg
// Shared constants and types for the NAND bus timing sequencer.
// Assumes a 32-bit register interface and 4-bit phase fields.
package nand_seq_pkg;

    localparam int FIELD_W    = 4;
    localparam int TIMING_W   = 8 * FIELD_W;
    localparam int HALF_W     = TIMING_W / 2;
    localparam int REG_AW     = 4;
    localparam int REG_DW     = 32;
    localparam int BUS_W      = 8;
    localparam int IRQ_N      = 2;

    localparam logic [REG_AW-1:0] A_CFG     = 4'd0;
    localparam logic [REG_AW-1:0] A_CTRL    = 4'd1;
    localparam logic [REG_AW-1:0] A_STAT    = 4'd2;
    localparam logic [REG_AW-1:0] A_IRQ_RAW = 4'd3;
    localparam logic [REG_AW-1:0] A_IRQ_EN  = 4'd4;
    localparam logic [REG_AW-1:0] A_IRQ_CLR = 4'd5;
    localparam logic [REG_AW-1:0] A_TIMING  = 4'd6;
    localparam logic [REG_AW-1:0] A_CMD     = 4'd7;
    localparam logic [REG_AW-1:0] A_ADDR    = 4'd8;
    localparam logic [REG_AW-1:0] A_DATA    = 4'd9;
    localparam logic [REG_AW-1:0] A_COUNT   = 4'd10;

    localparam int CE_FORCE_BIT = 5;
    localparam int SOFT_RST_BIT = 2;
    localparam int IRQ_RDY_BIT  = 0;
    localparam int IRQ_TC_BIT   = 1;

    // Kind of bus cycle being run
    typedef enum logic [1:0] {
        CYC_DATA_WR = 2'd0,
        CYC_CMD     = 2'd1,
        CYC_ADDR    = 2'd2,
        CYC_DATA_RD = 2'd3
    } cyc_kind_e;

    // Sequencer phase
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_RWAIT  = 3'd4
    } phase_e;

    // One half of the timing register; setup sits in the low bits
    typedef struct packed {
        logic [FIELD_W-1:0] rdy_wait;
        logic [FIELD_W-1:0] width;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] setup;
    } phase_times_t;

endpackage

// File: rtl/nand_rdy_sync.sv
// nand_rdy_sync
// Brings the asynchronous ready/busy pin into the clock domain and
// flags its low-to-high transitions.
// Assumes STAGES >= 2.
module nand_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchroniser and keep the last level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign level = sync_q[STAGES-1];
    assign rise  = sync_q[STAGES-1] & ~prev_q;

    // R9: a transition flag lasts one clock
    p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/nand_seq_regs.sv
// nand_seq_regs
// Register file: decodes host accesses, holds configuration, timing,
// interrupt flags and the data-cycle counter, and issues cycle requests.
// Assumes host reads of non-data registers are side-effect free.
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int TC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_DW-1:0]    reg_wdata,
    output logic [REG_DW-1:0]    reg_rdata,
    input  logic                 rdy_level,
    input  logic                 rdy_rise,
    input  logic                 seq_busy,
    input  logic                 data_done,
    input  logic [BUS_W-1:0]     rd_byte,
    output logic                 start,
    output cyc_kind_e            start_kind,
    output logic [BUS_W-1:0]     start_byte,
    output logic [TIMING_W-1:0]  timing,
    output logic                 ce_force,
    output logic                 soft_rst,
    output logic                 irq
);

    localparam int PAD_CNT = REG_DW - TC_W;
    localparam int PAD_RAW = REG_DW - IRQ_N;

    logic                ce_force_q;
    logic [TIMING_W-1:0] timing_q;
    logic [IRQ_N-1:0]    irq_en_q;
    logic [IRQ_N-1:0]    irq_raw_q;
    logic [TC_W-1:0]     count_q;
    logic [IRQ_N-1:0]    irq_set;
    logic [IRQ_N-1:0]    irq_clr;
    logic                wr_count;
    logic                tc_hit;
    logic                req_wr;
    logic                req_rd;

    // Soft reset request taken straight from the write
    assign soft_rst = reg_wr && (reg_addr == A_CTRL) && reg_wdata[SOFT_RST_BIT];

    // Cycle request decode; refused while a cycle runs
    always_comb begin
        req_wr     = reg_wr && ((reg_addr == A_CMD) || (reg_addr == A_ADDR) ||
                                (reg_addr == A_DATA));
        req_rd     = !reg_wr && reg_rd && (reg_addr == A_DATA);
        start      = (req_wr || req_rd) && !seq_busy && !soft_rst;
        start_byte = reg_wdata[BUS_W-1:0];
        if (req_rd)                     start_kind = CYC_DATA_RD;
        else if (reg_addr == A_CMD)     start_kind = CYC_CMD;
        else if (reg_addr == A_ADDR)    start_kind = CYC_ADDR;
        else                            start_kind = CYC_DATA_WR;
    end

    // Interrupt set and clear terms
    always_comb begin
        wr_count              = reg_wr && (reg_addr == A_COUNT);
        tc_hit                = data_done && (count_q == TC_W'(1)) && !wr_count;
        irq_set               = '0;
        irq_set[IRQ_RDY_BIT]  = rdy_rise;
        irq_set[IRQ_TC_BIT]   = tc_hit;
        irq_clr               = (reg_wr && (reg_addr == A_IRQ_CLR)) ?
                                reg_wdata[IRQ_N-1:0] : '0;
    end

    // Register state, with hardware and software reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ce_force_q <= 1'b0;
            timing_q   <= '0;
            irq_en_q   <= '0;
            irq_raw_q  <= '0;
            count_q    <= '0;
        end else begin
            if (reg_wr && (reg_addr == A_CFG))
                ce_force_q <= reg_wdata[CE_FORCE_BIT];
            if (reg_wr && (reg_addr == A_TIMING))
                timing_q <= reg_wdata[TIMING_W-1:0];
            if (reg_wr && (reg_addr == A_IRQ_EN))
                irq_en_q <= reg_wdata[IRQ_N-1:0];
            if (wr_count)
                count_q <= reg_wdata[TC_W-1:0];
            else if (data_done && (count_q != '0))
                count_q <= count_q - 1'b1;
            irq_raw_q <= irq_set | (irq_raw_q & ~irq_clr);
        end
    end

    // Read data mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG:     reg_rdata[CE_FORCE_BIT] = ce_force_q;
            A_STAT:    reg_rdata[0]            = rdy_level;
            A_IRQ_RAW: reg_rdata = {{PAD_RAW{1'b0}}, irq_raw_q};
            A_IRQ_EN:  reg_rdata = {{PAD_RAW{1'b0}}, irq_en_q};
            A_TIMING:  reg_rdata[TIMING_W-1:0] = timing_q;
            A_DATA:    reg_rdata[BUS_W-1:0]    = rd_byte;
            A_COUNT:   reg_rdata = {{PAD_CNT{1'b0}}, count_q};
            default:   reg_rdata = '0;
        endcase
    end

    assign timing   = timing_q;
    assign ce_force = ce_force_q;
    assign irq      = |(irq_raw_q & irq_en_q);

    // R10: a ready transition always leaves the flag set
    p_rdy_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_rise && !soft_rst) |=> irq_raw_q[IRQ_RDY_BIT]);

    // R10: writing a one to the clear register removes the ready flag
    p_clr_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_IRQ_CLR) && reg_wdata[IRQ_RDY_BIT] && !rdy_rise)
        |=> !irq_raw_q[IRQ_RDY_BIT]);

    // R11: the last counted data cycle raises the terminal-count flag
    p_tc_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (data_done && (count_q == TC_W'(1)) && !wr_count && !soft_rst)
        |=> irq_raw_q[IRQ_TC_BIT]);

    // R12: software reset clears configuration and masks
    p_soft_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((timing_q == '0) && !ce_force_q && (irq_en_q == '0)));

endmodule

// File: rtl/nand_phase_seq.sv
// nand_phase_seq
// Runs one bus cycle through setup, strobe, hold and ready-wait phases,
// each lasting its programmed count plus one clock.
// Assumes start is only raised while idle; clr aborts at once.
module nand_phase_seq
    import nand_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 start,
    input  cyc_kind_e            start_kind,
    input  logic [BUS_W-1:0]     start_byte,
    input  logic [TIMING_W-1:0]  timing,
    input  logic                 ce_force,
    input  logic [BUS_W-1:0]     dq_in,
    output logic                 ce_n,
    output logic                 cle,
    output logic                 ale,
    output logic                 we_n,
    output logic                 re_n,
    output logic [BUS_W-1:0]     dq_out,
    output logic                 dq_oe,
    output logic                 busy,
    output logic                 rd_done,
    output logic [BUS_W-1:0]     rd_byte,
    output logic                 data_done
);

    phase_e              phase_q;
    cyc_kind_e           kind_q;
    logic [FIELD_W-1:0]  cnt_q;
    logic [BUS_W-1:0]    byte_q;
    logic [BUS_W-1:0]    rd_byte_q;
    phase_times_t        times_q;
    phase_times_t        sel_times;
    logic                rd_done_q;
    logic                data_done_q;
    logic                cnt_zero;
    logic                latch_phase;
    logic                is_read;

    // Pick the read or write half of the timing register for a new cycle
    assign sel_times = (start_kind == CYC_DATA_RD) ?
                       phase_times_t'(timing[HALF_W-1:0]) :
                       phase_times_t'(timing[TIMING_W-1:HALF_W]);

    assign cnt_zero = (cnt_q == '0);
    assign is_read  = (kind_q == CYC_DATA_RD);

    // Phase state machine and per-phase down-counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q     <= PH_IDLE;
            kind_q      <= CYC_DATA_WR;
            cnt_q       <= '0;
            byte_q      <= '0;
            rd_byte_q   <= '0;
            times_q     <= '0;
            rd_done_q   <= 1'b0;
            data_done_q <= 1'b0;
        end else begin
            rd_done_q   <= 1'b0;
            data_done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_SETUP;
                        kind_q  <= start_kind;
                        byte_q  <= start_byte;
                        times_q <= sel_times;
                        cnt_q   <= sel_times.setup;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= times_q.width;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt_zero) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= times_q.hold;
                        if (is_read)
                            rd_byte_q <= dq_in;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_zero) begin
                        phase_q <= PH_RWAIT;
                        cnt_q   <= times_q.rdy_wait;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_RWAIT: begin
                    if (cnt_zero) begin
                        phase_q     <= PH_IDLE;
                        rd_done_q   <= is_read;
                        data_done_q <= is_read || (kind_q == CYC_DATA_WR);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Bus pin decode from the current phase and cycle kind
    always_comb begin
        latch_phase = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) ||
                      (phase_q == PH_HOLD);
        busy   = (phase_q != PH_IDLE);
        ce_n   = !(ce_force || busy);
        cle    = latch_phase && (kind_q == CYC_CMD);
        ale    = latch_phase && (kind_q == CYC_ADDR);
        we_n   = !((phase_q == PH_STROBE) && !is_read);
        re_n   = !((phase_q == PH_STROBE) && is_read);
        dq_oe  = latch_phase && !is_read;
        dq_out = byte_q;
    end

    assign rd_done   = rd_done_q;
    assign rd_byte   = rd_byte_q;
    assign data_done = data_done_q;

    // R6: the two strobes are never active together
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R3: command and address latches are exclusive
    p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R7: any strobe happens with the chip enabled
    p_ce_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);

    // R6: the write strobe falls only after a setup phase
    p_setup_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(phase_q == PH_SETUP));

    // R8: the register file requests a cycle only when idle
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R5: the bus is never driven while reading
    p_read_undriven_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);

    // R5: the read completion pulse follows the ready-wait phase
    p_rd_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(phase_q == PH_RWAIT));

endmodule

// File: rtl/nand_bus_seq.sv
// nand_bus_seq
// Top level: register-driven sequencer for an 8-bit asynchronous NAND bus.
// Assumes the host waits for seq_busy low before issuing the next cycle.
module nand_bus_seq
    import nand_seq_pkg::*;
#(
    parameter int TC_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [3:0]   reg_addr,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  reg_rdata,
    output logic         seq_busy,
    output logic         rd_done,
    output logic [7:0]   rd_byte,
    output logic         nand_ce_n,
    output logic         nand_cle,
    output logic         nand_ale,
    output logic         nand_we_n,
    output logic         nand_re_n,
    output logic [7:0]   nand_dq_out,
    output logic         nand_dq_oe,
    input  logic [7:0]   nand_dq_in,
    input  logic         nand_rdy,
    output logic         irq
);

    logic                rdy_level;
    logic                rdy_rise;
    logic                start;
    cyc_kind_e           start_kind;
    logic [BUS_W-1:0]    start_byte;
    logic [TIMING_W-1:0] timing;
    logic                ce_force;
    logic                soft_rst;
    logic                data_done;

    nand_rdy_sync #(
        .STAGES (SYNC_STAGES)
    ) u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (nand_rdy),
        .level (rdy_level),
        .rise  (rdy_rise)
    );

    nand_seq_regs #(
        .TC_W (TC_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .rdy_level  (rdy_level),
        .rdy_rise   (rdy_rise),
        .seq_busy   (seq_busy),
        .data_done  (data_done),
        .rd_byte    (rd_byte),
        .start      (start),
        .start_kind (start_kind),
        .start_byte (start_byte),
        .timing     (timing),
        .ce_force   (ce_force),
        .soft_rst   (soft_rst),
        .irq        (irq)
    );

    nand_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_rst),
        .start      (start),
        .start_kind (start_kind),
        .start_byte (start_byte),
        .timing     (timing),
        .ce_force   (ce_force),
        .dq_in      (nand_dq_in),
        .ce_n       (nand_ce_n),
        .cle        (nand_cle),
        .ale        (nand_ale),
        .we_n       (nand_we_n),
        .re_n       (nand_re_n),
        .dq_out     (nand_dq_out),
        .dq_oe      (nand_dq_oe),
        .busy       (seq_busy),
        .rd_done    (rd_done),
        .rd_byte    (rd_byte),
        .data_done  (data_done)
    );

endmodule

// File: tb/nand_bus_seq_bench.sv
// nand_bus_seq_bench
// Scoreboard bench: driver tasks queue the expected strobes, a monitor
// compares each finished strobe against the queue.
module nand_bus_seq_bench;

    localparam logic [3:0] R_CFG = 4'd0, R_CTRL = 4'd1, R_STAT = 4'd2,
                           R_RAW = 4'd3, R_EN = 4'd4, R_CLR = 4'd5,
                           R_TIM = 4'd6, R_CMD = 4'd7, R_ADR = 4'd8,
                           R_DAT = 4'd9, R_CNT = 4'd10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        seq_busy, rd_done;
    logic [7:0]  rd_byte;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_dq_oe, nand_rdy, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [31:0] tim_val;
    logic [15:0] expq[$];   // {kind[1:0], byte[7:0], width[5:0]}

    always #4 clk = ~clk;

    nand_bus_seq u_nand_bus_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_busy(seq_busy), .rd_done(rd_done), .rd_byte(rd_byte),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy), .irq(irq)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic bus_read();
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = R_DAT;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (seq_busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Write strobe width n+1 for write fields, read field for reads
    function automatic logic [5:0] wr_width();
        return 6'(tim_val[27:24]) + 6'd1;
    endfunction
    function automatic logic [5:0] rd_width();
        return 6'(tim_val[11:8]) + 6'd1;
    endfunction

    task automatic push(input logic [1:0] k, input logic [7:0] b, input logic [5:0] w);
        expq.push_back({k, b, w});
    endtask

    // Monitor: compare each completed strobe with the queue front
    task automatic compare(input logic [1:0] k, input logic [7:0] b, input int w);
        logic [15:0] e;
        string tag;
        if (expq.size() == 0) begin
            check(1'b0, "R8 unexpected strobe", {22'd0, k, b}, 32'd0);
            return;
        end
        e = expq.pop_front();
        case (e[15:14])
            2'd1:    tag = "R2";
            2'd2:    tag = "R3";
            2'd3:    tag = "R5";
            default: tag = "R4";
        endcase
        check(k == e[15:14], {tag, " kind"}, 32'(k), 32'(e[15:14]));
        check(b == e[13:6],  {tag, " byte"}, 32'(b), 32'(e[13:6]));
        check(w == int'(e[5:0]), "R6 strobe width", 32'(w), 32'(e[5:0]));
    endtask

    int we_low = 0, re_low = 0;
    logic [1:0] we_kind;
    logic [7:0] we_byte;
    logic       oe_bad = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            we_low = 0; re_low = 0;
        end else begin
            if (!nand_we_n) begin
                we_low++;
                we_kind = nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd0);
                if (nand_cle && nand_ale) we_kind = 2'd3;
                we_byte = nand_dq_out;
            end else if (we_low > 0) begin
                compare(we_kind, we_byte, we_low);
                we_low = 0;
            end
            if (!nand_re_n) begin
                re_low++;
                if (nand_dq_oe || nand_cle || nand_ale) oe_bad = 1'b1;
            end else if (re_low > 0) begin
                compare(2'd3, rd_byte, re_low);
                re_low = 0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        bit saw_done;
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
        reg_wdata = '0; nand_dq_in = 8'h00; nand_rdy = 1'b0; tim_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle pin levels after reset
        check({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, irq, seq_busy}
              == 8'b1110_0000, "R1 pins",
              {24'd0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, irq, seq_busy},
              32'hE0);
        rd_reg(R_TIM, d); check(d == 32'd0, "R1 timing", d, 32'd0);
        rd_reg(R_RAW, d); check(d == 32'd0, "R1 flags", d, 32'd0);

        // R6: field layout readback
        tim_val = 32'h2131_1203;
        wr_reg(R_TIM, tim_val);
        rd_reg(R_TIM, d); check(d == tim_val, "R6 timing readback", d, tim_val);
        wr_reg(R_CNT, 32'd2);

        // R2: command cycle
        push(2'd1, 8'h70, wr_width());
        wr_reg(R_CMD, 32'h0000_0A70);
        check(!nand_ce_n, "R7 ce during cycle", 32'(nand_ce_n), 32'd0);
        wait_idle(n);
        check(n == 11, "R6 write busy length", n, 11);
        check(nand_ce_n, "R7 ce after cycle", 32'(nand_ce_n), 32'd1);

        // R3: address cycle
        push(2'd2, 8'h34, wr_width());
        wr_reg(R_ADR, 32'h0000_1234);
        wait_idle(n);

        // R4: data write, also first counted data cycle
        push(2'd0, 8'hC3, wr_width());
        wr_reg(R_DAT, 32'h0000_FFC3);
        wait_idle(n);
        rd_reg(R_CNT, d); check(d == 32'd1, "R11 count after write", d, 32'd1);
        rd_reg(R_RAW, d); check(d[1] == 1'b0, "R11 no early tc", d, 32'd0);

        // R5: data read, terminal count reached
        nand_dq_in = 8'hA5;
        push(2'd3, 8'hA5, rd_width());
        bus_read();
        wait_idle(n);
        check(n == 10, "R6 read busy length", n, 10);
        saw_done = rd_done;
        check(saw_done, "R5 rd_done pulse", 32'(saw_done), 32'd1);
        @(negedge clk);
        check(!rd_done, "R5 rd_done one clock", 32'(rd_done), 32'd0);
        rd_reg(R_DAT, d); check(d == 32'hA5, "R5 data readback", d, 32'hA5);
        check(!oe_bad, "R5 bus undriven on read", 32'(oe_bad), 32'd0);
        rd_reg(R_RAW, d); check(d == 32'd2, "R11 tc flag", d, 32'd2);
        rd_reg(R_CNT, d); check(d == 32'd0, "R11 count at zero", d, 32'd0);

        // R10: masking and clearing
        check(!irq, "R10 irq masked", 32'(irq), 32'd0);
        wr_reg(R_EN, 32'd2);
        #1 check(irq, "R10 irq enabled", 32'(irq), 32'd1);
        wr_reg(R_CLR, 32'd2);
        rd_reg(R_RAW, d); check(d == 32'd0, "R10 cleared", d, 32'd0);
        check(!irq, "R10 irq after clear", 32'(irq), 32'd0);

        // R8: second access while busy is ignored
        tim_val = 32'h001F_0000;
        wr_reg(R_TIM, tim_val);
        push(2'd1, 8'h90, wr_width());
        wr_reg(R_CMD, 32'h90);
        wr_reg(R_ADR, 32'h55);
        bus_read();
        wait_idle(n);
        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R8 only one strobe", expq.size(), 0);

        // R7: forced chip enable
        wr_reg(R_CFG, 32'h20);
        check(!nand_ce_n, "R7 forced low", 32'(nand_ce_n), 32'd0);
        rd_reg(R_CFG, d); check(d == 32'h20, "R7 cfg readback", d, 32'h20);
        wr_reg(R_CFG, 32'h0);
        check(nand_ce_n, "R7 released", 32'(nand_ce_n), 32'd1);

        // R9 / R10: ready line and its interrupt
        rd_reg(R_STAT, d); check(d == 32'd0, "R9 busy status", d, 32'd0);
        @(negedge clk); nand_rdy = 1'b1;
        @(negedge clk);
        #1 check(reg_rdata == 32'd0, "R9 sync delay", reg_rdata, 32'd0);
        @(negedge clk);
        #1 check(reg_rdata == 32'd1, "R9 ready status", reg_rdata, 32'd1);
        repeat (2) @(negedge clk);
        rd_reg(R_RAW, d); check(d == 32'd1, "R10 ready flag", d, 32'd1);
        wr_reg(R_EN, 32'd1);
        #1 check(irq, "R10 ready irq", 32'(irq), 32'd1);
        wr_reg(R_CLR, 32'd1);
        #1 check(!irq, "R10 ready cleared", 32'(irq), 32'd0);

        // R12: soft reset aborts a cycle in setup
        wr_reg(R_TIM, 32'h000F_0000);
        wr_reg(R_CFG, 32'h20);
        wr_reg(R_CMD, 32'h11);
        check(seq_busy, "R12 cycle started", 32'(seq_busy), 32'd1);
        wr_reg(R_CTRL, 32'h4);
        check(!seq_busy && nand_ce_n && nand_we_n, "R12 aborted",
              {29'd0, seq_busy, nand_ce_n, nand_we_n}, 32'd3);
        rd_reg(R_TIM, d); check(d == 32'd0, "R12 timing cleared", d, 32'd0);
        rd_reg(R_EN, d);  check(d == 32'd0, "R12 mask cleared", d, 32'd0);
        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R8 queue drained", expq.size(), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule